// File: doc/BRIEF.md
# Stack-Based Call and Return Sequencer

This block is the control sequencer that a small processor core uses for subroutine linkage and interrupt linkage. It owns the program counter, the stack pointer and the status word. The status word holds the condition flags, the execution mode and the global interrupt enable. The decoder presents one-cycle strobes for call, return, return-from-interrupt and plain sequential steps. The block then runs the push and pop sequences on a single-port memory and raises a busy line, so that fetch stalls until the sequence is over.

The stack grows toward lower addresses. A push first lowers the stack pointer by one word and writes to the new address. A pop reads at the current stack pointer and then raises it by one word. Interrupt entry stores two words: the address of the interrupted instruction, then the status word. It then moves to a fixed vector, sets the mode bit and clears the enable bit. Return-from-interrupt undoes this in the opposite order, so the restored word brings back the flags, the mode and the enable together.

Top module: `call_ret_seq`

## Requirements
- R1: After reset the program counter equals PC_RST, the stack pointer equals SP_RST, the status word is 0x20 (flags 0, mode 0, enable 1), and busy and the memory request are low.
- R2: A call accepted in an idle cycle lowers the stack pointer by one, writes PC+1 to the new stack-pointer address, and then loads the target into the program counter.
- R3: A return accepted in an idle cycle reads the word at the stack pointer into the program counter and raises the stack pointer by one.
- R4: With the enable (status bit 5) set, a high interrupt line in an idle cycle with no strobe present starts interrupt entry. Entry pushes the current PC, then pushes the status word zero-extended to a full word. It leaves the PC at VEC, sets mode (bit 4), clears the enable and keeps the flags (bits 3:0).
- R5: Return-from-interrupt pops the status word first and the PC second. The stack pointer ends two words higher, and flags, mode and enable all take the popped values.
- R6: While the enable is clear, a high interrupt line changes nothing: PC, stack pointer and status hold and busy stays low.
- R7: A call and an interrupt present in the same cycle are handled as follows. The call completes in full first. Entry then follows and saves the call target as the interrupted address.
- R8: While busy is high, all strobes (call, return, return-from-interrupt, step, flag write) are ignored.
- R9: A memory request keeps its address, write enable and write data unchanged until it is acknowledged. Wait states only lengthen busy.
- R10: With zero-wait memory, busy is high for exactly one cycle per stack word moved: 1 for call and return, 2 for entry and for return-from-interrupt.
- R11: In an idle cycle a step adds one to the PC. A flag write replaces status bits 3:0 and leaves mode and enable unchanged.
- R12: When several strobes arrive in one idle cycle, only one is taken. Call wins over return, return over return-from-interrupt, and that over step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Decoded call strobe |
| ret_i | input | 1 | Decoded return strobe |
| iret_i | input | 1 | Decoded return-from-interrupt strobe |
| step_i | input | 1 | Decoded sequential instruction strobe |
| tgt_i | input | AW | Call target address, valid with call_i |
| flags_we_i | input | 1 | Flag write from the execution stage |
| flags_i | input | FW | New flag values |
| irq_i | input | 1 | Level interrupt request |
| pc_o | output | AW | Program counter |
| sp_o | output | AW | Stack pointer |
| stat_o | output | FW+2 | Status word: flags, mode, enable |
| busy_o | output | 1 | Holds fetch while a stack sequence runs |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (push) when high, read (pop) when low |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | AW | Memory write data |
| mem_rdata_i | input | AW | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge, completes the request |

## Verification
The bench arrives with a call and an interrupt in the same cycle. A sequencer that broke the linkage would either push the wrong return address or enter the vector before the target is loaded, and the saved address would then not equal the target. It pokes strobes and flag writes into the middle of a sequence. A design that listened while busy would corrupt the stack pointer or the flags. It counts busy cycles against zero-wait memory, which exposes extra or missing memory cycles. It also pops status words with the enable set and clear, which catches a restore that skips the mode or the enable bit. A random phase with wait states then shows whether addresses drift while a request waits, because the words would land in the wrong slots.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_PUSH_PC = 3'd1,
    S_PUSH_ST = 3'd2,
    S_POP_ST  = 3'd3,
    S_POP_PC  = 3'd4
  } seq_st_e;

  // bit positions inside the status word are relative to the flag width
  function automatic int unsigned mode_bit(input int unsigned fw);
    return fw;
  endfunction

  function automatic int unsigned ie_bit(input int unsigned fw);
    return fw + 1;
  endfunction

endpackage

// File: rtl/crs_sp.sv
module crs_sp #(
  parameter int unsigned AW     = 16,
  parameter int unsigned SP_RST = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_done_i,
  input  logic          pop_done_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] push_addr_o
);

  function automatic logic [AW-1:0] below(input logic [AW-1:0] a);
    return a - AW'(1);
  endfunction

  function automatic logic [AW-1:0] above(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= AW'(SP_RST);
    end else if (push_done_i) begin
      sp_q <= below(sp_q);
    end else if (pop_done_i) begin
      sp_q <= above(sp_q);
    end
  end

  assign sp_o        = sp_q;
  assign push_addr_o = below(sp_q);

endmodule

// File: rtl/crs_status.sv
module crs_status
  import crs_pkg::*;
#(
  parameter int unsigned FW = 4,
  localparam int unsigned SW = FW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flags_we_i,
  input  logic [FW-1:0] flags_i,
  input  logic          enter_i,
  input  logic          restore_i,
  input  logic [SW-1:0] restore_d_i,
  output logic [SW-1:0] stat_o
);

  localparam int unsigned MB = mode_bit(FW);
  localparam int unsigned EB = ie_bit(FW);

  function automatic logic [SW-1:0] reset_word();
    logic [SW-1:0] w;
    w     = '0;
    w[EB] = 1'b1;
    return w;
  endfunction

  function automatic logic [SW-1:0] entry_word(input logic [SW-1:0] s);
    logic [SW-1:0] w;
    w     = s;
    w[MB] = 1'b1;
    w[EB] = 1'b0;
    return w;
  endfunction

  logic [SW-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= reset_word();
    end else if (restore_i) begin
      stat_q <= restore_d_i;
    end else if (enter_i) begin
      stat_q <= entry_word(stat_q);
    end else if (flags_we_i) begin
      stat_q[FW-1:0] <= flags_i;
    end
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/crs_ctl.sv
module crs_ctl
  import crs_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned SW     = 6,
  parameter int unsigned PC_RST = 0,
  parameter int unsigned VEC    = 'h8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          iret_i,
  input  logic          step_i,
  input  logic          flags_we_i,
  input  logic          irq_i,
  input  logic [AW-1:0] tgt_i,
  input  logic [SW-1:0] stat_i,
  input  logic          ie_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          mem_ack_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic [AW-1:0] pc_o,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  output logic          push_done_o,
  output logic          pop_done_o,
  output logic          restore_o,
  output logic [SW-1:0] restore_d_o,
  output logic          idle_o,
  output logic          acc_call_o,
  output logic          acc_ret_o,
  output logic          acc_iret_o,
  output logic          acc_step_o,
  output logic          acc_int_o
);

  function automatic logic [AW-1:0] next_seq(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  seq_st_e       st_q;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] tgt_q;
  logic [AW-1:0] hold_q;
  logic [SW-1:0] sav_q;
  logic          is_int_q;
  logic [AW-1:0] sav_word;
  logic          mem_done;
  logic          any_ins;
  logic          pushing;

  // status word widened to one stack word
  generate
    if (AW > SW) begin : g_pad
      assign sav_word = {{(AW-SW){1'b0}}, sav_q};
    end else begin : g_fit
      assign sav_word = sav_q;
    end
  endgenerate

  // acceptance, fixed priority, interrupt only when no strobe is present
  assign idle_o     = (st_q == S_IDLE);
  assign any_ins    = call_i | ret_i | iret_i | step_i | flags_we_i;
  assign acc_call_o = idle_o & call_i;
  assign acc_ret_o  = idle_o & ret_i & ~call_i;
  assign acc_iret_o = idle_o & iret_i & ~call_i & ~ret_i;
  assign acc_step_o = idle_o & step_i & ~call_i & ~ret_i & ~iret_i;
  assign acc_int_o  = idle_o & irq_i & ie_i & ~any_ins;

  assign pushing     = (st_q == S_PUSH_PC) | (st_q == S_PUSH_ST);
  assign mem_req_o   = ~idle_o;
  assign mem_we_o    = pushing;
  assign mem_addr_o  = pushing ? push_addr_i : sp_i;
  assign mem_wdata_o = (st_q == S_PUSH_ST) ? sav_word : hold_q;
  assign mem_done    = mem_req_o & mem_ack_i;
  assign push_done_o = mem_done & pushing;
  assign pop_done_o  = mem_done & ~pushing;
  assign restore_o   = mem_done & (st_q == S_POP_ST);
  assign restore_d_o = mem_rdata_i[SW-1:0];
  assign busy_o      = ~idle_o;
  assign pc_o        = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      pc_q     <= AW'(PC_RST);
      tgt_q    <= '0;
      hold_q   <= '0;
      sav_q    <= '0;
      is_int_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (acc_call_o) begin
            tgt_q    <= tgt_i;
            hold_q   <= next_seq(pc_q);
            is_int_q <= 1'b0;
            st_q     <= S_PUSH_PC;
          end else if (acc_ret_o) begin
            st_q <= S_POP_PC;
          end else if (acc_iret_o) begin
            st_q <= S_POP_ST;
          end else if (acc_step_o) begin
            pc_q <= next_seq(pc_q);
          end else if (acc_int_o) begin
            hold_q   <= pc_q;
            sav_q    <= stat_i;
            is_int_q <= 1'b1;
            st_q     <= S_PUSH_PC;
          end
        end
        S_PUSH_PC: begin
          if (mem_done) begin
            if (is_int_q) begin
              st_q <= S_PUSH_ST;
            end else begin
              pc_q <= tgt_q;
              st_q <= S_IDLE;
            end
          end
        end
        S_PUSH_ST: begin
          if (mem_done) begin
            pc_q <= AW'(VEC);
            st_q <= S_IDLE;
          end
        end
        S_POP_ST: begin
          if (mem_done) begin
            st_q <= S_POP_PC;
          end
        end
        S_POP_PC: begin
          if (mem_done) begin
            pc_q <= mem_rdata_i;
            st_q <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/call_ret_seq.sv
module call_ret_seq #(
  parameter int unsigned AW     = 16,
  parameter int unsigned FW     = 4,
  parameter int unsigned PC_RST = 0,
  parameter int unsigned SP_RST = 'h100,
  parameter int unsigned VEC    = 'h8,
  localparam int unsigned SW    = FW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          iret_i,
  input  logic          step_i,
  input  logic [AW-1:0] tgt_i,
  input  logic          flags_we_i,
  input  logic [FW-1:0] flags_i,
  input  logic          irq_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o,
  output logic [SW-1:0] stat_o,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic [AW-1:0] mem_rdata_i,
  input  logic          mem_ack_i
);

  // named internal events, observed by the bound checker
  logic          push_done;
  logic          pop_done;
  logic          restore;
  logic [SW-1:0] restore_d;
  logic          idle;
  logic          acc_call;
  logic          acc_ret;
  logic          acc_iret;
  logic          acc_step;
  logic          acc_int;
  logic [AW-1:0] push_addr;
  logic          st_ie;
  logic          st_mode;

  assign st_ie   = stat_o[FW+1];
  assign st_mode = stat_o[FW];

  crs_sp #(
    .AW    (AW),
    .SP_RST(SP_RST)
  ) u_sp (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_done_i(push_done),
    .pop_done_i (pop_done),
    .sp_o       (sp_o),
    .push_addr_o(push_addr)
  );

  crs_status #(
    .FW(FW)
  ) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags_we_i (flags_we_i & idle),
    .flags_i    (flags_i),
    .enter_i    (acc_int),
    .restore_i  (restore),
    .restore_d_i(restore_d),
    .stat_o     (stat_o)
  );

  crs_ctl #(
    .AW    (AW),
    .SW    (SW),
    .PC_RST(PC_RST),
    .VEC   (VEC)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .iret_i     (iret_i),
    .step_i     (step_i),
    .flags_we_i (flags_we_i),
    .irq_i      (irq_i),
    .tgt_i      (tgt_i),
    .stat_i     (stat_o),
    .ie_i       (st_ie),
    .sp_i       (sp_o),
    .push_addr_i(push_addr),
    .mem_ack_i  (mem_ack_i),
    .mem_rdata_i(mem_rdata_i),
    .pc_o       (pc_o),
    .busy_o     (busy_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .push_done_o(push_done),
    .pop_done_o (pop_done),
    .restore_o  (restore),
    .restore_d_o(restore_d),
    .idle_o     (idle),
    .acc_call_o (acc_call),
    .acc_ret_o  (acc_ret),
    .acc_iret_o (acc_iret),
    .acc_step_o (acc_step),
    .acc_int_o  (acc_int)
  );

endmodule

// File: rtl/crs_chk.sv
module crs_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] sp,
  input logic          acc_call,
  input logic          acc_ret,
  input logic          acc_iret,
  input logic          acc_step,
  input logic          acc_int,
  input logic          ie,
  input logic          mode
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R2
  sp_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_ack) |=> $stable(sp));

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ack) |=> $stable(pc));

  // R12
  one_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_call, acc_ret, acc_iret, acc_step, acc_int}));

  // R4
  int_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_int |=> (!ie && mode && busy));

  // R7
  call_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_call |=> !acc_int);

endmodule

bind call_ret_seq crs_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy_o),
  .mem_req  (mem_req_o),
  .mem_ack  (mem_ack_i),
  .mem_we   (mem_we_o),
  .mem_addr (mem_addr_o),
  .mem_wdata(mem_wdata_o),
  .pc       (pc_o),
  .sp       (sp_o),
  .acc_call (acc_call),
  .acc_ret  (acc_ret),
  .acc_iret (acc_iret),
  .acc_step (acc_step),
  .acc_int  (acc_int),
  .ie       (st_ie),
  .mode     (st_mode)
);

// File: tb/test_call_ret_seq.sv
module test_call_ret_seq;

  localparam int CLK_PER = 10;
  localparam int AW = 16;
  localparam int FW = 4;
  localparam int SW = FW + 2;
  localparam logic [15:0] VEC_A = 16'h0008;

  localparam int K_STEP = 0, K_CALL = 1, K_RET = 2, K_IRET = 3, K_FLAG = 4, K_IRQ = 5, K_MULTI = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_i = 0, ret_i = 0, iret_i = 0, step_i = 0, flags_we_i = 0, irq_i = 0;
  logic [AW-1:0] tgt_i = '0;
  logic [FW-1:0] flags_i = '0;
  logic [AW-1:0] pc_o, sp_o, mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [SW-1:0] stat_o;
  logic busy_o, mem_req_o, mem_we_o, mem_ack_i;

  always #(CLK_PER/2) clk = ~clk;

  call_ret_seq i_call_ret_seq (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .iret_i(iret_i),
    .step_i(step_i), .tgt_i(tgt_i), .flags_we_i(flags_we_i), .flags_i(flags_i),
    .irq_i(irq_i), .pc_o(pc_o), .sp_o(sp_o), .stat_o(stat_o), .busy_o(busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  // memory with random wait states
  logic [15:0] ram [256];
  int maxd = 0;
  int wcnt = 0;
  int cur_dly = 0;
  assign mem_ack_i   = mem_req_o && (wcnt == cur_dly);
  assign mem_rdata_i = ram[mem_addr_o[7:0]];

  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_ack_i) begin
        if (mem_we_o) ram[mem_addr_o[7:0]] <= mem_wdata_o;
        wcnt    <= 0;
        cur_dly <= (maxd == 0) ? 0 : int'($urandom_range(maxd, 0));
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // bench model
  logic [15:0] m_pc, m_sp;
  logic [5:0]  m_st;
  logic [15:0] m_mem [256];
  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [5:0] entry_st(input logic [5:0] s);
    return {1'b0, 1'b1, s[3:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic m_push(input logic [15:0] w);
    m_sp = m_sp - 16'd1;
    m_mem[m_sp[7:0]] = w;
  endtask

  task automatic m_pop(output logic [15:0] w);
    w = m_mem[m_sp[7:0]];
    m_sp = m_sp + 16'd1;
  endtask

  task automatic m_enter();
    if (m_st[5]) begin
      m_push(m_pc);
      m_push({10'd0, m_st});
      m_st = entry_st(m_st);
      m_pc = VEC_A;
    end
  endtask

  task automatic check_all(input string req);
    logic [7:0] ix;
    chk(req, "pc", pc_o, m_pc);
    chk(req, "sp", sp_o, m_sp);
    chk(req, "status", {10'd0, stat_o}, {10'd0, m_st});
    for (int i = 0; i < 2; i++) begin
      ix = m_sp[7:0] + 8'(i);
      chk((maxd > 0) ? "R9" : req, "stack word", ram[ix], m_mem[ix]);
    end
  endtask

  // runs one operation and returns the number of busy cycles seen
  task automatic run_op(input int kind, input logic [15:0] t, input logic [3:0] f,
                        input bit with_irq, input bit poke, output int bcyc);
    logic [15:0] w;
    int guard;
    bcyc = 0;
    guard = 0;
    while (busy_o && guard < 200) begin @(negedge clk); guard++; end
    tgt_i = t;
    flags_i = f;
    case (kind)
      K_STEP:  step_i = 1;
      K_CALL:  call_i = 1;
      K_RET:   ret_i = 1;
      K_IRET:  iret_i = 1;
      K_FLAG:  flags_we_i = 1;
      K_IRQ:   irq_i = 1;
      default: begin call_i = 1; ret_i = 1; step_i = 1; end
    endcase
    if (with_irq) irq_i = 1;
    @(negedge clk);
    call_i = 0; ret_i = 0; iret_i = 0; step_i = 0; flags_we_i = 0;
    if (!with_irq) irq_i = 0;
    if (poke && busy_o) begin
      ret_i = 1; iret_i = 1; step_i = 1; flags_we_i = 1; flags_i = ~f;
    end
    while (busy_o && guard < 200) begin
      bcyc++;
      @(negedge clk);
      ret_i = 0; iret_i = 0; step_i = 0; flags_we_i = 0;
      guard++;
    end
    if (with_irq) begin
      @(negedge clk);
      irq_i = 0;
      while (busy_o && guard < 200) begin @(negedge clk); guard++; end
    end
    if (guard >= 200) begin
      n_chk++; n_bad++;
      $display("FAIL R9 busy never fell actual=1 expected=0");
    end
    // model
    case (kind)
      K_STEP:  m_pc = m_pc + 16'd1;
      K_CALL, K_MULTI: begin m_push(m_pc + 16'd1); m_pc = t; end
      K_RET:   begin m_pop(w); m_pc = w; end
      K_IRET:  begin m_pop(w); m_st = w[5:0]; m_pop(w); m_pc = w; end
      K_FLAG:  m_st[3:0] = f;
      default: m_enter();
    endcase
    if (with_irq) m_enter();
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog run hung actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int bc;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin ram[i] = 16'd0; m_mem[i] = 16'd0; end
    m_pc = 16'h0000; m_sp = 16'h0100; m_st = 6'h20;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "pc", pc_o, 16'h0000);
    chk("R1", "sp", sp_o, 16'h0100);
    chk("R1", "status", {10'd0, stat_o}, 16'h0020);
    chk("R1", "busy", {15'd0, busy_o}, 16'd0);
    chk("R1", "req", {15'd0, mem_req_o}, 16'd0);

    // R11 step and flag write
    run_op(K_STEP, 0, 0, 0, 0, bc);   check_all("R11");
    run_op(K_FLAG, 0, 4'hA, 0, 0, bc); check_all("R11");

    // R2 / R10 call, R3 / R10 return, zero wait
    run_op(K_CALL, 16'h0340, 0, 0, 0, bc); check_all("R2");
    chk("R10", "call busy cycles", 16'(bc), 16'd1);
    chk("R2", "pushed return address", ram[8'hFF], 16'h0002);
    run_op(K_RET, 0, 0, 0, 0, bc); check_all("R3");
    chk("R10", "return busy cycles", 16'(bc), 16'd1);

    // R4 / R10 entry, R6 masked, R5 / R10 return-from-interrupt
    run_op(K_IRQ, 0, 0, 0, 0, bc); check_all("R4");
    chk("R10", "entry busy cycles", 16'(bc), 16'd2);
    chk("R4", "saved status word", ram[8'hFE], 16'h002A);
    run_op(K_IRQ, 0, 0, 0, 0, bc); check_all("R6");
    chk("R6", "masked busy cycles", 16'(bc), 16'd0);
    run_op(K_FLAG, 0, 4'h3, 0, 0, bc); check_all("R11");
    run_op(K_IRET, 0, 0, 0, 0, bc); check_all("R5");
    chk("R10", "iret busy cycles", 16'(bc), 16'd2);

    // R7 call and interrupt together
    run_op(K_CALL, 16'h0500, 0, 1, 0, bc); check_all("R7");
    chk("R7", "interrupted address is target", ram[8'hFE], 16'h0500);
    chk("R7", "call return address", ram[8'hFF], 16'h0003);
    run_op(K_IRET, 0, 0, 0, 0, bc); check_all("R5");
    run_op(K_RET, 0, 0, 0, 0, bc); check_all("R3");

    // R8 strobes during busy
    run_op(K_CALL, 16'h0777, 4'h5, 0, 1, bc); check_all("R8");
    run_op(K_RET, 0, 4'h6, 0, 1, bc); check_all("R8");

    // R12 several strobes
    run_op(K_MULTI, 16'h0123, 0, 0, 0, bc); check_all("R12");
    run_op(K_RET, 0, 0, 0, 0, bc); check_all("R3");

    // random phase with wait states
    maxd = 2;
    for (int n = 0; n < 400; n++) begin
      int r;
      int k;
      r = int'($urandom_range(99, 0));
      if (r < 22) k = K_CALL;
      else if (r < 40) k = K_RET;
      else if (r < 58) k = K_STEP;
      else if (r < 70) k = K_FLAG;
      else if (r < 85) k = K_IRQ;
      else if (r < 95) k = K_IRET;
      else k = K_MULTI;
      run_op(k, 16'($urandom), 4'($urandom), ($urandom_range(9, 0) == 0) && (k == K_CALL),
             ($urandom_range(4, 0) == 0) && (k == K_CALL || k == K_RET), bc);
      case (k)
        K_CALL:  check_all("R2");
        K_RET:   check_all("R3");
        K_IRQ:   check_all("R4");
        K_IRET:  check_all("R5");
        K_MULTI: check_all("R12");
        default: check_all("R11");
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule